// File: doc/BRIEF.md
# Card Write-Data Sequencer

This block runs the data phase of a write command for a flash-card host that uses a single data line. Once the command path reports that the command went out and the card answered, the host arms the data phase. The sequencer then takes bytes from a host-filled transmit FIFO, one per byte slot, and serializes them into framed blocks. Each block is a start bit, the payload, a 16-bit CRC and an end bit. After a block it releases the line, reads the card's three-bit status token and waits while the card holds the line low for busy.

Each serial bit slot is marked by a card-clock enable output. When the FIFO runs dry in the middle of a block, the sequencer stops issuing bit slots and holds the line driven until the host refills the FIFO and re-asserts data-enable. In multiblock mode it parks after every block. From there the host either continues with the next block or ends the transfer, which asks the command path for a stop command. A block length of zero selects an open-ended stream with no CRC framing, and only the end request terminates it. Four single-cycle interrupt pulses report the transfer events.

Top module: `card_wr_seq`

## Requirements
- R1: After reset, dat_oe, card_clk_en, busy, fifo_rd, stop_req, all four irq outputs and the three error flags are 0.
- R2: data_en has no effect until a cmd_done pulse has been seen in idle. A cmd_timeout pulse in idle sets resp_tmo_err and starts no data.
- R3: A block is sent on consecutive card_clk_en slots with dat_oe high, in this order: a 0 start bit, then each byte MSB first, then 16 CRC bits MSB first, then a 1 end bit. The CRC uses polynomial 0x1021, starts at 0 and covers the payload bits only.
- R4: fifo_rd pulses exactly once per payload byte, and fifo_data is taken in that same cycle.
- R5: If a byte is needed and fifo_empty is high, irq_fifo_empty pulses and the line stays driven (dat_oe=1) with no card_clk_en. A later data_en resumes the stream exactly where it stopped.
- R6: irq_xfer_end pulses after the end bit. The line is then released for 2 slots, and 3 token bits are sampled from dat_in, first arrival as MSB. irq_resp then pulses, and crc_err is set unless the token arrived as 0,1,0.
- R7: After the token, busy stays high until the first slot in which dat_in is sampled high. irq_busy_end pulses at that point.
- R8: If dat_in stays low for BUSY_LIMIT busy slots, busy_tmo is set, busy drops and irq_busy_end does not pulse.
- R9: With multi_mode=1 the sequencer parks after each block with the line released. data_en starts the next block with a start bit. cmd_off pulses stop_req and returns to idle.
- R10: With multi_mode=0 the sequencer returns to idle after a block, and data_en is then ignored until a new cmd_done.
- R11: blk_len=0 streams bytes with no CRC or end bit. The stream stops on an empty FIFO, and cmd_off while stopped pulses stop_req, releases the line and raises no irq_xfer_end.
- R12: A cmd_done accepted in idle clears crc_err, busy_tmo and resp_tmo_err.
- R13: Every irq output is a one-cycle pulse, and at most one irq or stop_req is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| multi_mode | input | 1 | 1: park after each block |
| blk_len | input | LEN_W | Bytes per block, 0 = open stream |
| cmd_done | input | 1 | Command sent and response received |
| cmd_timeout | input | 1 | Command response missing |
| data_en | input | 1 | Start or resume the data phase |
| cmd_off | input | 1 | End the sequence |
| fifo_empty | input | 1 | Transmit FIFO empty |
| fifo_data | input | DW | FIFO head byte |
| fifo_rd | output | 1 | Pop FIFO head |
| dat_in | input | 1 | Data line level from card |
| dat_out | output | 1 | Data line drive value |
| dat_oe | output | 1 | Data line drive enable |
| card_clk_en | output | 1 | One serial bit slot this cycle |
| busy | output | 1 | Card busy wait in progress |
| crc_err | output | 1 | Bad status token seen |
| busy_tmo | output | 1 | Busy wait timed out |
| resp_tmo_err | output | 1 | Command response timeout seen |
| stop_req | output | 1 | Pulse: issue stop command |
| irq_xfer_end | output | 1 | Pulse: end bit sent |
| irq_resp | output | 1 | Pulse: status token received |
| irq_fifo_empty | output | 1 | Pulse: paused on empty FIFO |
| irq_busy_end | output | 1 | Pulse: busy released |

## Verification
Several properties are checked on every cycle: the line is always turned on with a low start bit and released only after a high level, a pause on an empty FIFO keeps the line driven with no bit slot, busy can end only through the busy-end pulse or the timeout flag, the interrupt pulses are single and mutually exclusive, and stop_req appears only with the line released. Other points need the bench scenarios. These include the bit-exact framing and CRC values, resuming mid-block after a refill, classifying good and bad tokens, the busy duration, parking between blocks, the open stream ended by cmd_off, and ignoring data_en when the sequencer is not armed.

// File: rtl/wds_pkg.sv
package wds_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_READY, S_START, S_LOAD, S_DATA, S_PAUSE,
    S_CRC, S_END, S_GAP, S_TOK, S_BUSY, S_PARK
  } wds_state_e;
endpackage

// File: rtl/wds_crc16.sv
module wds_crc16 #(
  parameter int          W    = 16,
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic shift,
  input  logic bit_in,
  output logic crc_msb
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  assign fb = crc_q[W-1] ^ bit_in;

  always_comb begin
    crc_d = crc_q;
    if (clr)        crc_d = '0;
    else if (upd)   crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
    else if (shift) crc_d = {crc_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;

  assign crc_msb = crc_q[W-1];

  // R3: the remainder only moves on a commanded operation
  p_crc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr || upd || shift) |=> $stable(crc_q));
endmodule

// File: rtl/wds_busy_timer.sv
module wds_busy_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (en && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  // R8: the count never passes the limit
  p_tmr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/card_wr_seq.sv
module card_wr_seq
  import wds_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LEN_W      = 12,
  parameter int BUSY_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             multi_mode,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             cmd_done,
  input  logic             cmd_timeout,
  input  logic             data_en,
  input  logic             cmd_off,
  input  logic             fifo_empty,
  input  logic [DW-1:0]    fifo_data,
  output logic             fifo_rd,
  input  logic             dat_in,
  output logic             dat_out,
  output logic             dat_oe,
  output logic             card_clk_en,
  output logic             busy,
  output logic             crc_err,
  output logic             busy_tmo,
  output logic             resp_tmo_err,
  output logic             stop_req,
  output logic             irq_xfer_end,
  output logic             irq_resp,
  output logic             irq_fifo_empty,
  output logic             irq_busy_end
);
  localparam int CRC_W   = 16;
  localparam int CNT_MAX = (CRC_W > DW) ? CRC_W : DW;
  localparam int CNT_W   = $clog2(CNT_MAX);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_i_n = rs_q[1];

  wds_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic [1:0]       tok_q, tok_d;
  logic             lim_q, lim_d;
  logic             cerr_q, cerr_d, btmo_q, btmo_d, rtmo_q, rtmo_d;
  logic             xend_q, xend_d, resp_q, resp_d, fe_q, fe_d;
  logic             bend_q, bend_d, stop_q, stop_d;
  logic             crc_clr, crc_upd, crc_shift, crc_msb;
  logic             tmr_clr, tmr_en, tmr_exp;

  wds_crc16 #(.W(CRC_W), .POLY(16'h1021)) u_crc (
    .clk(clk), .rst_n(rst_i_n), .clr(crc_clr), .upd(crc_upd),
    .shift(crc_shift), .bit_in(sh_q[DW-1]), .crc_msb(crc_msb)
  );

  wds_busy_timer #(.LIMIT(BUSY_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .clr(tmr_clr), .en(tmr_en), .expired(tmr_exp)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  left_d = left_q;  sh_d = sh_q;
    tok_d = tok_q;  lim_d = lim_q;
    cerr_d = cerr_q;  btmo_d = btmo_q;  rtmo_d = rtmo_q;
    xend_d = 1'b0;  resp_d = 1'b0;  fe_d = 1'b0;  bend_d = 1'b0;  stop_d = 1'b0;
    crc_clr = 1'b0;  crc_upd = 1'b0;  crc_shift = 1'b0;
    tmr_clr = 1'b0;  tmr_en = 1'b0;  fifo_rd = 1'b0;
    unique case (st_q)
      S_IDLE:
        if (cmd_done) begin
          st_d = S_READY;  cerr_d = 1'b0;  btmo_d = 1'b0;  rtmo_d = 1'b0;
        end else if (cmd_timeout) rtmo_d = 1'b1;
      S_READY, S_PARK:
        if (st_q == S_PARK && cmd_off) begin
          stop_d = 1'b1;  st_d = S_IDLE;
        end else if (data_en) begin
          st_d = S_START;  left_d = blk_len;  lim_d = |blk_len;  crc_clr = 1'b1;
        end
      S_START: st_d = S_LOAD;
      S_LOAD:
        if (fifo_empty) begin
          fe_d = 1'b1;  st_d = S_PAUSE;
        end else begin
          fifo_rd = 1'b1;  sh_d = fifo_data;  cnt_d = CNT_W'(DW - 1);  st_d = S_DATA;
        end
      S_DATA: begin
        crc_upd = 1'b1;
        sh_d    = {sh_q[DW-2:0], 1'b0};
        if (cnt_q == '0) begin
          left_d = left_q - 1'b1;
          if (lim_q && left_q == LEN_W'(1)) begin
            st_d = S_CRC;  cnt_d = CNT_W'(CRC_W - 1);
          end else st_d = S_LOAD;
        end else cnt_d = cnt_q - 1'b1;
      end
      S_PAUSE:
        if (cmd_off) begin
          stop_d = 1'b1;  st_d = S_IDLE;
        end else if (data_en) st_d = S_LOAD;
      S_CRC: begin
        crc_shift = 1'b1;
        if (cnt_q == '0) st_d = S_END;
        else             cnt_d = cnt_q - 1'b1;
      end
      S_END: begin
        xend_d = 1'b1;  st_d = S_GAP;  cnt_d = CNT_W'(1);
      end
      S_GAP:
        if (cnt_q == '0) begin
          st_d = S_TOK;  cnt_d = CNT_W'(2);
        end else cnt_d = cnt_q - 1'b1;
      S_TOK: begin
        tok_d = {tok_q[0], dat_in};
        if (cnt_q == '0) begin
          resp_d  = 1'b1;
          cerr_d  = cerr_q | ({tok_q, dat_in} != 3'b010);
          tmr_clr = 1'b1;
          st_d    = S_BUSY;
        end else cnt_d = cnt_q - 1'b1;
      end
      S_BUSY: begin
        tmr_en = 1'b1;
        if (dat_in) begin
          bend_d = 1'b1;  st_d = multi_mode ? S_PARK : S_IDLE;
        end else if (tmr_exp) begin
          btmo_d = 1'b1;  st_d = multi_mode ? S_PARK : S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n)
    if (!rst_i_n) begin
      st_q <= S_IDLE;  cnt_q <= '0;  left_q <= '0;  sh_q <= '0;  tok_q <= '0;
      lim_q <= 1'b0;  cerr_q <= 1'b0;  btmo_q <= 1'b0;  rtmo_q <= 1'b0;
      xend_q <= 1'b0;  resp_q <= 1'b0;  fe_q <= 1'b0;  bend_q <= 1'b0;  stop_q <= 1'b0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  left_q <= left_d;  sh_q <= sh_d;  tok_q <= tok_d;
      lim_q <= lim_d;  cerr_q <= cerr_d;  btmo_q <= btmo_d;  rtmo_q <= rtmo_d;
      xend_q <= xend_d;  resp_q <= resp_d;  fe_q <= fe_d;  bend_q <= bend_d;  stop_q <= stop_d;
    end

  // outputs
  assign dat_oe      = st_q inside {S_START, S_LOAD, S_DATA, S_PAUSE, S_CRC, S_END};
  assign card_clk_en = st_q inside {S_START, S_DATA, S_CRC, S_END, S_GAP, S_TOK, S_BUSY};
  assign busy        = (st_q == S_BUSY);

  always_comb
    unique case (st_q)
      S_START: dat_out = 1'b0;
      S_DATA:  dat_out = sh_q[DW-1];
      S_CRC:   dat_out = crc_msb;
      default: dat_out = 1'b1;
    endcase

  assign crc_err        = cerr_q;
  assign busy_tmo       = btmo_q;
  assign resp_tmo_err   = rtmo_q;
  assign stop_req       = stop_q;
  assign irq_xfer_end   = xend_q;
  assign irq_resp       = resp_q;
  assign irq_fifo_empty = fe_q;
  assign irq_busy_end   = bend_q;

  // assertions
  p_drive_on_low_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(dat_oe) |-> !dat_out);
  p_release_high_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(dat_oe) |-> $past(dat_out));
  p_pause_holds_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq_fifo_empty |-> (dat_oe && !card_clk_en));
  p_busy_exit_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(busy) |-> (irq_busy_end || busy_tmo));
  p_stop_released_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    stop_req |-> (!dat_oe && !card_clk_en));
  p_irq_onehot_r13: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({irq_xfer_end, irq_resp, irq_fifo_empty, irq_busy_end, stop_req}));
  p_fe_single_r13: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq_fifo_empty |=> !irq_fifo_empty);
  p_resp_single_r13: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq_resp |=> !irq_resp);
endmodule

// File: tb/card_wr_seq_tb_top.sv
`timescale 1ns/1ps
module card_wr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        multi_mode, cmd_done, cmd_timeout, data_en, cmd_off;
  logic [11:0] blk_len;
  logic        fifo_empty, fifo_rd;
  logic [7:0]  fifo_data;
  logic        dat_in = 1'b1;
  logic        dat_out, dat_oe, card_clk_en, busy, crc_err, busy_tmo, resp_tmo_err;
  logic        stop_req, irq_xfer_end, irq_resp, irq_fifo_empty, irq_busy_end;

  always #5 clk = ~clk;

  card_wr_seq #(.DW(8), .LEN_W(12), .BUSY_LIMIT(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .multi_mode(multi_mode), .blk_len(blk_len),
    .cmd_done(cmd_done), .cmd_timeout(cmd_timeout), .data_en(data_en), .cmd_off(cmd_off),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe), .card_clk_en(card_clk_en),
    .busy(busy), .crc_err(crc_err), .busy_tmo(busy_tmo), .resp_tmo_err(resp_tmo_err),
    .stop_req(stop_req), .irq_xfer_end(irq_xfer_end), .irq_resp(irq_resp),
    .irq_fifo_empty(irq_fifo_empty), .irq_busy_end(irq_busy_end)
  );

  int checks = 0, failures = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench FIFO model
  logic [7:0]  fifo_mem [16];
  logic [31:0] rd_ptr = 0, wr_ptr = 0;
  logic        pop_pend = 1'b0;
  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_data  = fifo_mem[rd_ptr[3:0]];

  task automatic fill(input logic [7:0] b);
    fifo_mem[wr_ptr[3:0]] = b;
    wr_ptr++;
  endtask

  // scoreboard of expected serial bits
  bit          exp_q[$];
  logic [15:0] sb_crc;

  task automatic sb_start();
    exp_q.push_back(1'b0);
    sb_crc = '0;
  endtask

  task automatic sb_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      exp_q.push_back(b[i]);
      fb     = sb_crc[15] ^ b[i];
      sb_crc = {sb_crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
  endtask

  task automatic sb_close();
    for (int i = 15; i >= 0; i--) exp_q.push_back(sb_crc[i]);
    exp_q.push_back(1'b1);
  endtask

  task automatic load(input logic [7:0] b);
    fill(b);
    sb_byte(b);
  endtask

  // card model settings
  logic [2:0] tok_pat = 3'b010;
  int         busy_len = 0;
  int         k = 0;

  // monitor counters
  int n_rd = 0, n_oe = 0, n_xend = 0, n_resp = 0, n_fe = 0, n_bend = 0, n_stop = 0;
  int n_busy_cyc = 0, n_bdone = 0, n_irq_viol = 0;
  logic busy_prev = 1'b0;
  logic [4:0] irq_prev = '0;

  always @(negedge clk) begin
    if (pop_pend) begin
      rd_ptr++;
      n_rd++;
    end
    pop_pend = fifo_rd;
    if (rst_n) begin
      if (dat_oe) begin
        n_oe++;
        k = 0;
        if (card_clk_en) begin
          if (exp_q.size() == 0) chk("R3 unexpected bit", 1, 0);
          else chk("R3 serial bit", dat_out, exp_q.pop_front());
        end
      end else if (card_clk_en) begin
        if (k < 2)      dat_in = 1'b1;
        else if (k < 5) dat_in = tok_pat[4-k];
        else            dat_in = (k < 5 + busy_len) ? 1'b0 : 1'b1;
        k++;
      end
      if (irq_xfer_end)   n_xend++;
      if (irq_resp)       n_resp++;
      if (irq_fifo_empty) n_fe++;
      if (irq_busy_end)   n_bend++;
      if (stop_req)       n_stop++;
      if (busy)           n_busy_cyc++;
      if (busy_prev && !busy) n_bdone++;
      busy_prev = busy;
      if ($countones({irq_xfer_end, irq_resp, irq_fifo_empty, irq_busy_end, stop_req}) > 1)
        n_irq_viol++;
      if ((irq_prev & {irq_xfer_end, irq_resp, irq_fifo_empty, irq_busy_end, 1'b0}) != 0)
        n_irq_viol++;
      irq_prev = {irq_xfer_end, irq_resp, irq_fifo_empty, irq_busy_end, 1'b0};
    end
  end

  task automatic pulse_done();    cmd_done = 1;    @(negedge clk); cmd_done = 0;    endtask
  task automatic pulse_tmo();     cmd_timeout = 1; @(negedge clk); cmd_timeout = 0; endtask
  task automatic pulse_en();      data_en = 1;     @(negedge clk); data_en = 0;     endtask
  task automatic pulse_off();     cmd_off = 1;     @(negedge clk); cmd_off = 0;     endtask

  task automatic wait_bdone();
    int t;
    t = n_bdone + 1;
    while (n_bdone < t) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_fe();
    int t;
    t = n_fe + 1;
    while (n_fe < t) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s_oe, s_rd, s_bend, s_busy, s_xend;
    rst_n = 0; multi_mode = 0; blk_len = '0;
    cmd_done = 0; cmd_timeout = 0; data_en = 0; cmd_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 dat_oe", dat_oe, 0);
    chk("R1 card_clk_en", card_clk_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 irqs", {irq_xfer_end, irq_resp, irq_fifo_empty, irq_busy_end, stop_req, fifo_rd}, 0);
    chk("R1 flags", {crc_err, busy_tmo, resp_tmo_err}, 0);

    // R2 not armed, response timeout
    pulse_en();
    repeat (6) @(negedge clk);
    chk("R2 data_en before cmd_done", n_oe, 0);
    pulse_tmo();
    chk("R2 resp_tmo_err set", resp_tmo_err, 1);
    pulse_en();
    repeat (4) @(negedge clk);
    chk("R2 no data after timeout", n_oe, 0);

    // single block, FIFO holds it all
    blk_len = 12'd4;
    pulse_done();
    chk("R12 resp_tmo_err cleared", resp_tmo_err, 0);
    sb_start(); load(8'hA5); load(8'h3C); load(8'h00); load(8'hF1); sb_close();
    tok_pat = 3'b010; busy_len = 3;
    s_busy = n_busy_cyc;
    pulse_en();
    wait_bdone();
    chk("R3 frame fully sent", exp_q.size(), 0);
    chk("R4 one read per byte", n_rd, 4);
    chk("R6 xfer end pulses", n_xend, 1);
    chk("R6 resp pulses", n_resp, 1);
    chk("R6 good token", crc_err, 0);
    chk("R7 busy end pulses", n_bend, 1);
    chk("R7 busy cycles", n_busy_cyc - s_busy, 4);
    chk("R5 no pause when block fits", n_fe, 0);

    // R10 single mode back to idle
    s_oe = n_oe;
    pulse_en();
    repeat (6) @(negedge clk);
    chk("R10 data_en ignored after block", n_oe - s_oe, 0);

    // mid-block pause on empty FIFO, bad token
    blk_len = 12'd6;
    pulse_done();
    sb_start();
    load(8'h81); load(8'h7E); load(8'h55);
    sb_byte(8'h12); sb_byte(8'hC3); sb_byte(8'hFF); sb_close();
    tok_pat = 3'b101; busy_len = 0;
    pulse_en();
    wait_fe();
    repeat (3) @(negedge clk);
    chk("R5 line held in pause", dat_oe, 1);
    chk("R5 no bit slots in pause", card_clk_en, 0);
    chk("R5 bits left at pause", exp_q.size(), 24 + 17);
    s_rd = n_rd;
    fill(8'h12); fill(8'hC3); fill(8'hFF);
    pulse_en();
    wait_bdone();
    chk("R5 resumed frame complete", exp_q.size(), 0);
    chk("R4 reads after resume", n_rd - s_rd, 3);
    chk("R6 bad token flagged", crc_err, 1);

    // multiblock with park, busy timeout, stop
    multi_mode = 1; blk_len = 12'd2;
    pulse_done();
    chk("R12 crc_err cleared", crc_err, 0);
    sb_start(); load(8'h9D); load(8'h04); sb_close();
    tok_pat = 3'b010; busy_len = 1;
    pulse_en();
    wait_bdone();
    chk("R9 parked line released", dat_oe, 0);
    chk("R9 parked no slots", card_clk_en, 0);
    chk("R9 no stop yet", n_stop, 0);
    sb_start(); load(8'h6B); load(8'hE0); sb_close();
    busy_len = 200;
    s_bend = n_bend;
    pulse_en();
    wait_bdone();
    chk("R9 second block sent", exp_q.size(), 0);
    chk("R8 busy timeout flag", busy_tmo, 1);
    chk("R8 no busy end on timeout", n_bend - s_bend, 0);
    pulse_off();
    repeat (2) @(negedge clk);
    chk("R9 stop request", n_stop, 1);
    s_oe = n_oe;
    pulse_en();
    repeat (5) @(negedge clk);
    chk("R9 idle after stop", n_oe - s_oe, 0);

    // open stream, ended by cmd_off
    blk_len = 12'd0;
    pulse_done();
    chk("R12 busy_tmo cleared", busy_tmo, 0);
    sb_start(); load(8'h2F); load(8'hB4);
    s_xend = n_xend;
    pulse_en();
    wait_fe();
    repeat (2) @(negedge clk);
    chk("R11 stream bits sent, no CRC", exp_q.size(), 0);
    chk("R11 line held before stop", dat_oe, 1);
    pulse_off();
    repeat (2) @(negedge clk);
    chk("R11 line released", dat_oe, 0);
    chk("R11 stop request", n_stop, 2);
    chk("R11 no xfer end", n_xend - s_xend, 0);

    chk("R13 irq pulse shape", n_irq_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule